// File: doc/BRIEF.md
# Filtered Alarm Status Latch

This block turns per-channel out-of-limit flags into a filtered alarm status and an active-low alarm output. Each channel's flag arrives with a conversion-done strobe. A channel must be out of limit on N conversions in a row before its status bit sets. An in-range conversion restarts the count, so short glitches never raise an alarm.

The status bits run in one of two modes. In latched mode a set bit holds until two things are true: the fault has gone, and software has read the status register. In unlatched mode the bit simply follows the filtered condition. Each channel has an enable mask bit. The mask gates the alarm pin only and never touches the status bit. A small register port gives access to the control register, the enable mask and the read-only status register. A read of the status address acts as the status-read strobe.

Top module: `alarm_filter_status`

## Requirements
- R1: After reset the control register, enable mask, status register and read data are all 0, and alarm_n is 1.
- R2: A channel's status bit sets only after N consecutive conversions with its flag at 1, where N = control bits [7:4] + 1. A conversion with the flag at 0 restarts the count.
- R3: The per-channel count saturates at N and never exceeds 16. N = 1 alarms on the first out-of-limit conversion, and N = 16 needs sixteen.
- R4: In latched mode (control bit 0 = 0), a set bit stays at 1 after the condition subsides, until a status read.
- R5: In latched mode, a status read while the channel's condition is still active leaves its bit at 1.
- R6: A read of address 2 returns the pre-clear status on reg_rdata after the next edge. The clear takes effect one edge later. An out-of-limit conversion in that cycle keeps the bit set, and an in-range one lets it clear.
- R7: In unlatched mode (control bit 0 = 1), a bit returns to 0 at the first in-range conversion, without any read.
- R8: alarm_n is 0 exactly when some status bit is 1 and its enable bit (address 1) is 1. The mask never changes status.
- R9: Control bits other than bit 0 and bits [7:4] read back as 0. This includes the soft-reset bit 15.
- R10: Writes to the status address 2 have no effect.
- R11: Writing control bit 15 = 1 clears all counters and status bits in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a conversion result is present |
| oor_flags | input | CH | Per-channel out-of-limit flags, valid with conv_done |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; at address 2 this is the status read |
| reg_addr | input | AW | Register address: 0 control, 1 enable mask, 2 status |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| alarm_n | output | 1 | Active-low alarm pin |

## Verification
The hardest case is a status read whose clear cycle coincides with a conversion. The bench gets there by raising the read strobe on one cycle and the conversion strobe on the very next cycle, with the flag high in one pass and low in another. It then reads again to see whether the set or the clear won. The filter boundary is swept over every N from 1 to 16, both with unbroken runs and with runs broken one short of N. The pin mask is swept over all 256 values against a fixed latched pattern.

// File: rtl/alarm_filter_status.sv
module alarm_filter_status #(
  parameter int CH = 8,
  parameter int NW = 4,
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [CH-1:0] oor_flags,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          alarm_n
);
  localparam int CW = NW + 1;
  localparam int NLSB = 4;
  localparam int SRST = DW - 1;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);
  localparam logic [CW-1:0] CMAX = CW'(1) << NW;

  logic          latch_dis;
  logic [NW-1:0] ncfg;
  logic [CH-1:0] en;
  logic [CH-1:0] stat;
  logic [CH-1:0] stat_nxt;
  logic          clr_pend;

  wire [CW-1:0] nval    = CW'(ncfg) + CW'(1);
  wire          ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  wire          sw_rst  = ctrl_wr && reg_wdata[SRST];
  wire          stat_rd = reg_rd && (reg_addr == A_STAT);

  assign alarm_n = ~|(stat & en);

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic          act;

    always_comb begin
      cnt_nxt = cnt;
      if (conv_done) begin
        if (!oor_flags[g])     cnt_nxt = '0;
        else if (cnt >= nval)  cnt_nxt = nval;
        else                   cnt_nxt = cnt + CW'(1);
      end
    end

    assign act = cnt_nxt >= nval;
    assign stat_nxt[g] = latch_dis ? act
                       : ((stat[g] && !(clr_pend && !act)) || (conv_done && act));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cnt <= '0;
      else if (sw_rst) cnt <= '0;
      else             cnt <= cnt_nxt;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CMAX); // R3
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_dis <= 1'b0;
      ncfg      <= '0;
      en        <= '0;
      stat      <= '0;
      clr_pend  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      clr_pend <= stat_rd;
      stat     <= sw_rst ? '0 : stat_nxt;
      if (ctrl_wr) begin
        latch_dis <= reg_wdata[0];
        ncfg      <= reg_wdata[NLSB +: NW];
      end
      if (reg_wr && reg_addr == A_EN) en <= reg_wdata[CH-1:0];
      if (reg_rd) begin
        reg_rdata <= '0;
        case (reg_addr)
          A_CTRL: begin
            reg_rdata[0]         <= latch_dis;
            reg_rdata[NLSB +: NW] <= ncfg;
          end
          A_EN:   reg_rdata[CH-1:0] <= en;
          A_STAT: reg_rdata[CH-1:0] <= stat;
          default: ;
        endcase
      end
    end
  end

  AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ~$past(stat))) |-> ($past(conv_done) || $past(reg_wr))); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_dis && !clr_pend && !reg_wr) |=> ((stat & $past(stat)) == $past(stat))); // R4

  AST_UNLATCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_dis && conv_done && !reg_wr) |=> ((stat & ~$past(oor_flags)) == '0)); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_rd) && $past(reg_addr) == A_CTRL)
      |-> (reg_rdata[DW-1:NLSB+NW] == '0 && reg_rdata[NLSB-1:1] == '0)); // R9

  AST_SWRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_rst) |-> (stat == '0)); // R11
endmodule

// File: tb/alarm_filter_status_bench.sv
`timescale 1ns/1ps
module alarm_filter_status_bench;
  localparam int CH = 8;
  localparam int DW = 16;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_done = 1'b0;
  logic [CH-1:0] oor_flags = '0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic alarm_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alarm_filter_status #(.CH(CH), .NW(4), .DW(DW), .AW(AW)) u_alarm_filter_status (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .oor_flags(oor_flags),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_n(alarm_n));

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic conv(input logic [CH-1:0] f);
    @(negedge clk); conv_done = 1'b1; oor_flags = f;
    @(negedge clk); conv_done = 1'b0; oor_flags = '0;
  endtask

  function automatic logic [DW-1:0] ctl(input bit srst, input int n, input bit unl);
    return (DW'(srst) << 15) | (DW'(n - 1) << 4) | DW'(unl);
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 alarm_n", DW'(alarm_n), 16'h1);
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
    rd(2'd1, v); chk("R1 en", v, 16'h0);
    rd(2'd2, v); chk("R1 status", v, 16'h0);

    // R9 reserved bits
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R9 ctrl readback", v, 16'h00F1);

    // R2 / R3 sweep over every N
    for (int n = 1; n <= 16; n++) begin
      wr(2'd0, ctl(1, n, 0));
      for (int k = 1; k < n; k++) conv(8'h01);
      rd(2'd2, v); chk("R2 below N", v, 16'h0);
      conv(8'h01);
      rd(2'd2, v); chk("R3 at N", v, 16'h1);
      if (n >= 2) begin
        wr(2'd0, ctl(1, n, 0));
        for (int k = 1; k < n; k++) conv(8'h01);
        conv(8'h00);
        for (int k = 1; k < n; k++) conv(8'h01);
        rd(2'd2, v); chk("R2 broken run", v, 16'h0);
        conv(8'h01);
        rd(2'd2, v); chk("R2 after restart", v, 16'h1);
      end
    end

    // R2 multichannel: channel i out of limit for its first i conversions, N=3
    wr(2'd0, ctl(1, 3, 0));
    for (int c = 0; c < 8; c++) begin
      logic [CH-1:0] f;
      for (int i = 0; i < CH; i++) f[i] = (c < i);
      conv(f);
    end
    rd(2'd2, v); chk("R2 run lengths", v, 16'h00F8);

    // R4 / R5 latched behaviour, N=1
    wr(2'd0, ctl(1, 1, 0));
    conv(8'h01); conv(8'h00);
    rd(2'd2, v); chk("R4 held after subside", v, 16'h01);
    rd(2'd2, v); chk("R4 cleared by read", v, 16'h00);
    conv(8'h02);
    rd(2'd2, v); chk("R5 read while active", v, 16'h02);
    rd(2'd2, v); chk("R5 still set", v, 16'h02);
    conv(8'h00);
    rd(2'd2, v); chk("R4 pre-clear value", v, 16'h02);
    rd(2'd2, v); chk("R4 clear after subside", v, 16'h00);

    // R6 read strobe followed by conversion in the clear cycle
    conv(8'h04); conv(8'h00);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd2;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
    conv_done = 1'b1; oor_flags = 8'h04;
    @(negedge clk); conv_done = 1'b0; oor_flags = '0;
    chk("R6 pre-clear snapshot", v, 16'h04);
    conv(8'h00);
    rd(2'd2, v); chk("R6 set wins over clear", v, 16'h04);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd2;
    @(negedge clk); reg_rd = 1'b0;
    conv_done = 1'b1; oor_flags = 8'h00;
    @(negedge clk); conv_done = 1'b0;
    rd(2'd2, v); chk("R6 in-range clear", v, 16'h00);

    // R7 unlatched, N=2, watched on the pin without reads
    wr(2'd0, ctl(1, 2, 1));
    wr(2'd1, 16'h0008);
    conv(8'h08);
    chk("R7 one hit no alarm", DW'(alarm_n), 16'h1);
    conv(8'h08);
    chk("R7 alarm at N", DW'(alarm_n), 16'h0);
    conv(8'h00);
    chk("R7 auto clear", DW'(alarm_n), 16'h1);
    rd(2'd2, v); chk("R7 status clear", v, 16'h0);

    // R8 mask sweep against a fixed latched pattern
    wr(2'd0, ctl(1, 1, 0));
    conv(8'hA5);
    for (int m = 0; m < 256; m++) begin
      wr(2'd1, DW'(m));
      chk("R8 pin vs mask", DW'(alarm_n), DW'((8'(m) & 8'hA5) == 8'h00));
    end
    rd(2'd1, v); chk("R8 en readback", v, 16'h00FF);
    rd(2'd2, v); chk("R8 status unmasked", v, 16'h00A5);

    // R10 status write ignored
    wr(2'd2, 16'h0000);
    rd(2'd2, v); chk("R10 status after write 0", v, 16'h00A5);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, v); chk("R10 status after write 1s", v, 16'h00A5);

    // R11 soft reset clears counters and status
    wr(2'd0, ctl(1, 3, 0));
    rd(2'd2, v); chk("R11 status cleared", v, 16'h0);
    conv(8'h01); conv(8'h01);
    wr(2'd0, ctl(1, 3, 0));
    conv(8'h01);
    rd(2'd2, v); chk("R11 count restarted", v, 16'h0);
    conv(8'h01); conv(8'h01);
    rd(2'd2, v); chk("R11 sets after fresh run", v, 16'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule